// File: doc/BRIEF.md
# Multichannel 12/25 Complex Resampling Tuner

This block is the front end of a channel bank that serves many voice-band channels from one time-shared datapath. Real-valued samples for all channels arrive interleaved on a single strobed input, each tagged with its channel number and a per-sample tuning word. Every sample is first shifted in frequency by a per-channel numerically controlled oscillator, giving a complex baseband sample. That sample then enters a per-channel delay line. The rate is changed by the fixed ratio 12/25 (for example 8000 samples/s into 3840 samples/s). Conceptually the stream is zero-stuffed by 12, lowpass filtered by a 96-tap FIR and kept one sample in 25. Only the kept outputs are computed, as an 8-tap polyphase branch, on one shared multiply-accumulate pair.

Which input samples produce an output, and which polyphase branch each output uses, come from a 25-entry sequencing table fixed at elaboration. The table is indexed by each channel's position in its 25-sample cycle. No rate tracking takes place: the input-to-output count ratio is rigid. The controller has four states:

- IDLE moves to MIX when the strobe is seen.
- MIX mixes the sample, updates the channel state and moves to MAC if the table marks the position as emitting, and back to IDLE otherwise.
- MAC stays for 8 cycles, one tap per cycle, then moves to OUT.
- OUT registers the rounded result and returns to IDLE.

Samples must be spaced at least 12 clock cycles apart. A strobe that arrives outside IDLE is not taken.

Top module: `fdm_resampler`

## Requirements
- R1: After synchronous reset `out_valid` is 0. Every channel's oscillator phase, cycle position and delay line are cleared to zero.
- R2: Each channel owns a 16-bit phase accumulator. After each of that channel's samples, the accumulator advances by that sample's `in_freq`, modulo 2^16. Its top 4 bits k select entries of a 16-entry cosine table C. C[0..4] = 32767, 30274, 23170, 12540, 0. C[k] = -C[8-k] for k = 5..8, C[k] = -C[k-8] for k = 9..12, and C[k] = C[16-k] for k = 13..15.
- R3: The mixed sample uses the phase held before the update. It is I = floor(x·C[k] / 2^15) and Q = floor(x·C[(k+4) mod 16] / 2^15), with x the signed 16-bit input.
- R4: For the n-th sample of a channel (n counted from 0 after reset), let r = (−12·n) mod 25. An output is produced exactly when r < 12. This gives 12 outputs per 25 inputs and 144 outputs per 300 inputs on each channel.
- R5: An output is acc = Σ_{j=0..7} h[r+12j]·u[n−j], computed separately for I and Q. Here u are the channel's mixed samples, and samples before the first are 0. The coefficients are h[k] = 170·(k+1) for k < 48 and h[k] = 170·(96−k) for k ≥ 48.
- R6: Each output rail equals (acc + 2^14) shifted right arithmetically by 15, saturated to [−32768, 32767].
- R7: `out_valid` rises at the tenth rising clock edge after the edge that samples `in_valid`, and stays high for exactly one cycle. Nothing is emitted at the ninth edge.
- R8: `out_chan` gives the channel of the sample that produced the output. Channels do not disturb each other's phase, position or delay line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe, one cycle |
| in_chan | input | 5 | Channel of the input sample (below 24) |
| in_sample | input | 16 | Signed real input sample |
| in_freq | input | 16 | Phase increment applied after this sample |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 5 | Channel of the output sample |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |

## Verification
An output is due at the tenth rising edge after the edge that takes the strobe. That count covers one edge each for MIX and OUT and eight tap edges. The bench drives each sample on a falling edge and drops the strobe one cycle later. It confirms silence at the falling edge after the ninth edge, then samples the result at the falling edge after the tenth. A sample that the sequencing rule marks as silent must leave `out_valid` low at that same point. Samples are spaced 12 cycles apart, so each result is judged before the next sample is driven.

// File: rtl/fdm_rs_pkg.sv
package fdm_rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MIX,
        ST_MAC,
        ST_OUT
    } rs_state_e;

    localparam int NCO_IDX_W = 4;
    localparam int NCO_AMP_W = 16;

    // first quadrant of the oscillator amplitude, Q15
    function automatic logic signed [NCO_AMP_W-1:0] quarter_amp(input int q);
        case (q)
            0:       return 16'sd32767;
            1:       return 16'sd30274;
            2:       return 16'sd23170;
            3:       return 16'sd12540;
            default: return 16'sd0;
        endcase
    endfunction

    // full-cycle cosine built from quadrant symmetry
    function automatic logic signed [NCO_AMP_W-1:0] nco_cos(input logic [NCO_IDX_W-1:0] k);
        int ki;
        ki = int'(k);
        if (ki <= 4)       return quarter_amp(ki);
        else if (ki <= 8)  return -quarter_amp(8 - ki);
        else if (ki <= 12) return -quarter_amp(ki - 8);
        else               return quarter_amp(16 - ki);
    endfunction

    // triangular lowpass prototype of total length `total`
    function automatic int coef_val(input int k, input int total, input int scale);
        return (k < total / 2) ? scale * (k + 1) : scale * (total - k);
    endfunction

    // offset of the next kept output from input position s in the cycle
    function automatic int seq_offset(input int s, input int up, input int dn);
        return (dn - ((up * s) % dn)) % dn;
    endfunction

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import fdm_rs_pkg::*;
#(
    parameter int NCH  = 24,
    parameter int UP   = 12,
    parameter int DN   = 25,
    parameter int TAPS = 8,
    parameter int CHW  = 5,
    parameter int PHW  = 4,
    parameter int POSW = 5,
    parameter int TW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [CHW-1:0]  in_chan,
    output logic            accept,
    output logic [CHW-1:0]  chan,
    output logic            mix_en,
    output logic            mac_en,
    output logic            acc_clr,
    output logic            out_en,
    output logic [PHW-1:0]  branch,
    output logic [TW-1:0]   tap,
    output logic            out_valid,
    output logic [CHW-1:0]  out_chan
);

    rs_state_e state_q, state_d;

    logic [POSW-1:0] pos_mem [NCH];
    logic            seq_emit [DN];
    logic [PHW-1:0]  seq_ph [DN];
    logic [POSW-1:0] pos_cur;
    logic            emit_w;

    // sequencing table: emit flag and polyphase branch per cycle position
    for (genvar s = 0; s < DN; s++) begin : g_seq
        localparam int OFS = seq_offset(s, UP, DN);
        assign seq_emit[s] = (OFS < UP);
        assign seq_ph[s]   = PHW'(OFS % UP);
    end

    assign pos_cur = pos_mem[chan];
    assign emit_w  = seq_emit[pos_cur];

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        mix_en  = 1'b0;
        mac_en  = 1'b0;
        acc_clr = 1'b0;
        out_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    accept  = 1'b1;
                    state_d = ST_MIX;
                end
            end
            ST_MIX: begin
                mix_en  = 1'b1;
                acc_clr = 1'b1;
                state_d = emit_w ? ST_MAC : ST_IDLE;
            end
            ST_MAC: begin
                mac_en = 1'b1;
                if (tap == TW'(TAPS - 1)) state_d = ST_OUT;
            end
            ST_OUT: begin
                out_en  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // channel, tap, branch and per-channel cycle position
    always_ff @(posedge clk) begin
        if (rst) begin
            chan   <= '0;
            tap    <= '0;
            branch <= '0;
            for (int c = 0; c < NCH; c++) pos_mem[c] <= '0;
        end else begin
            if (accept) chan <= in_chan;
            if (mix_en) begin
                tap           <= '0;
                branch        <= seq_ph[pos_cur];
                pos_mem[chan] <= (pos_cur == POSW'(DN - 1)) ? '0 : pos_cur + POSW'(1);
            end
            if (mac_en) tap <= tap + TW'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
        end else begin
            out_valid <= out_en;
            if (out_en) out_chan <= chan;
        end
    end

endmodule

// File: rtl/rs_nco_mixer.sv
module rs_nco_mixer
    import fdm_rs_pkg::*;
#(
    parameter int NCH = 24,
    parameter int DW  = 16,
    parameter int PW  = 16,
    parameter int CHW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic signed [DW-1:0] in_sample,
    input  logic [PW-1:0]        in_freq,
    input  logic [CHW-1:0]       chan,
    input  logic                 mix_en,
    output logic signed [DW-1:0] mix_i,
    output logic signed [DW-1:0] mix_q
);

    logic signed [DW-1:0]           smp_q;
    logic [PW-1:0]                  frq_q;
    logic [PW-1:0]                  phase_mem [NCH];
    logic [NCO_IDX_W-1:0]           idx_c, idx_s;
    logic signed [NCO_AMP_W-1:0]    cos_v, nsin_v;
    logic signed [DW+NCO_AMP_W-1:0] prod_i, prod_q;
    logic                           unused_mix;

    assign idx_c  = phase_mem[chan][PW-1 -: NCO_IDX_W];
    assign idx_s  = idx_c + NCO_IDX_W'(4);
    assign cos_v  = nco_cos(idx_c);
    assign nsin_v = nco_cos(idx_s);
    assign prod_i = smp_q * cos_v;
    assign prod_q = smp_q * nsin_v;
    assign mix_i  = prod_i[NCO_AMP_W-1 +: DW];
    assign mix_q  = prod_q[NCO_AMP_W-1 +: DW];
    assign unused_mix = ^{prod_i, prod_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            frq_q <= '0;
            for (int c = 0; c < NCH; c++) phase_mem[c] <= '0;
        end else begin
            if (accept) begin
                smp_q <= in_sample;
                frq_q <= in_freq;
            end
            if (mix_en) phase_mem[chan] <= phase_mem[chan] + frq_q;
        end
    end

endmodule

// File: rtl/rs_delay_bank.sv
module rs_delay_bank #(
    parameter int NCH  = 24,
    parameter int TAPS = 8,
    parameter int DW   = 16,
    parameter int CHW  = 5,
    parameter int TW   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CHW-1:0]       chan,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_i,
    input  logic signed [DW-1:0] wr_q,
    input  logic [TW-1:0]        tap,
    output logic signed [DW-1:0] rd_i,
    output logic signed [DW-1:0] rd_q
);

    logic signed [DW-1:0] dl_i [NCH][TAPS];
    logic signed [DW-1:0] dl_q [NCH][TAPS];

    assign rd_i = dl_i[chan][tap];
    assign rd_q = dl_q[chan][tap];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                for (int j = 0; j < TAPS; j++) begin
                    dl_i[c][j] <= '0;
                    dl_q[c][j] <= '0;
                end
            end
        end else if (wr_en) begin
            for (int j = TAPS - 1; j > 0; j--) begin
                dl_i[chan][j] <= dl_i[chan][j-1];
                dl_q[chan][j] <= dl_q[chan][j-1];
            end
            dl_i[chan][0] <= wr_i;
            dl_q[chan][0] <= wr_q;
        end
    end

endmodule

// File: rtl/rs_mac.sv
module rs_mac
    import fdm_rs_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter int UP         = 12,
    parameter int TAPS       = 8,
    parameter int PHW        = 4,
    parameter int TW         = 3,
    parameter int ACCW       = 36,
    parameter int COEF_SCALE = 170
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 out_en,
    input  logic [PHW-1:0]       branch,
    input  logic [TW-1:0]        tap,
    input  logic signed [DW-1:0] rd_i,
    input  logic signed [DW-1:0] rd_q,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);

    localparam int NTOT = UP * TAPS;
    localparam logic signed [ACCW-1:0] RND_HALF = ACCW'(64'd1 << (CW - 2));
    localparam logic signed [ACCW-1:0] SAT_MAX  = ACCW'((64'd1 << (DW - 1)) - 64'd1);
    localparam logic signed [ACCW-1:0] SAT_MIN  = ~SAT_MAX;

    logic signed [CW-1:0]    cval;
    logic signed [DW+CW-1:0] prod_i, prod_q;
    logic signed [ACCW-1:0]  ext_i, ext_q;
    logic signed [ACCW-1:0]  acc_i, acc_q;

    always_comb cval = CW'(coef_val(int'(branch) + UP * int'(tap), NTOT, COEF_SCALE));

    assign prod_i = rd_i * cval;
    assign prod_q = rd_q * cval;
    assign ext_i  = $signed({{(ACCW-DW-CW){prod_i[DW+CW-1]}}, prod_i});
    assign ext_q  = $signed({{(ACCW-DW-CW){prod_q[DW+CW-1]}}, prod_q});

    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [ACCW-1:0] a);
        logic signed [ACCW-1:0] b;
        b = (a + RND_HALF) >>> (CW - 1);
        if (b > SAT_MAX)      return SAT_MAX[DW-1:0];
        else if (b < SAT_MIN) return SAT_MIN[DW-1:0];
        else                  return b[DW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (clr) begin
            acc_i <= '0;
            acc_q <= '0;
        end else if (en) begin
            acc_i <= acc_i + ext_i;
            acc_q <= acc_q + ext_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_i <= '0;
            out_q <= '0;
        end else if (out_en) begin
            out_i <= rnd_sat(acc_i);
            out_q <= rnd_sat(acc_q);
        end
    end

endmodule

// File: rtl/fdm_resampler.sv
module fdm_resampler #(
    parameter  int NCH        = 24,
    parameter  int DW         = 16,
    parameter  int CW         = 16,
    parameter  int PW         = 16,
    parameter  int UP         = 12,
    parameter  int DN         = 25,
    parameter  int TAPS       = 8,
    parameter  int COEF_SCALE = 170,
    localparam int CHW        = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [CHW-1:0]       in_chan,
    input  logic signed [DW-1:0] in_sample,
    input  logic [PW-1:0]        in_freq,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_chan,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);

    localparam int PHW  = $clog2(UP);
    localparam int POSW = $clog2(DN);
    localparam int TW   = $clog2(TAPS);
    localparam int ACCW = DW + CW + TW + 1;

    logic                 accept, mix_en, mac_en, acc_clr, out_en;
    logic [CHW-1:0]       chan;
    logic [PHW-1:0]       branch;
    logic [TW-1:0]        tap;
    logic signed [DW-1:0] mix_i, mix_q, rd_i, rd_q;

    rs_ctrl #(
        .NCH(NCH), .UP(UP), .DN(DN), .TAPS(TAPS),
        .CHW(CHW), .PHW(PHW), .POSW(POSW), .TW(TW)
    ) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .accept(accept), .chan(chan), .mix_en(mix_en), .mac_en(mac_en),
        .acc_clr(acc_clr), .out_en(out_en), .branch(branch), .tap(tap),
        .out_valid(out_valid), .out_chan(out_chan)
    );

    rs_nco_mixer #(
        .NCH(NCH), .DW(DW), .PW(PW), .CHW(CHW)
    ) u_mixer (
        .clk(clk), .rst(rst), .accept(accept), .in_sample(in_sample),
        .in_freq(in_freq), .chan(chan), .mix_en(mix_en),
        .mix_i(mix_i), .mix_q(mix_q)
    );

    rs_delay_bank #(
        .NCH(NCH), .TAPS(TAPS), .DW(DW), .CHW(CHW), .TW(TW)
    ) u_delay (
        .clk(clk), .rst(rst), .chan(chan), .wr_en(mix_en),
        .wr_i(mix_i), .wr_q(mix_q), .tap(tap), .rd_i(rd_i), .rd_q(rd_q)
    );

    rs_mac #(
        .DW(DW), .CW(CW), .UP(UP), .TAPS(TAPS), .PHW(PHW), .TW(TW),
        .ACCW(ACCW), .COEF_SCALE(COEF_SCALE)
    ) u_mac (
        .clk(clk), .rst(rst), .clr(acc_clr), .en(mac_en), .out_en(out_en),
        .branch(branch), .tap(tap), .rd_i(rd_i), .rd_q(rd_q),
        .out_i(out_i), .out_q(out_q)
    );

endmodule

// File: rtl/fdm_resampler_chk.sv
module fdm_resampler_chk #(
    parameter int CHW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           accept,
    input logic [CHW-1:0] in_chan,
    input logic           out_valid,
    input logic [CHW-1:0] out_chan
);

    logic [3:0]     since_q;
    logic [CHW-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            chan_q  <= '0;
        end else if (accept) begin
            since_q <= 4'd1;
            chan_q  <= in_chan;
        end else if (since_q != 4'd0 && since_q != 4'd15) begin
            since_q <= since_q + 4'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> since_q == 4'd11);

    // R8
    out_chan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_chan == chan_q);

endmodule

bind fdm_resampler fdm_resampler_chk #(.CHW(CHW)) u_fdm_resampler_chk (
    .clk(clk), .rst(rst), .accept(accept), .in_chan(in_chan),
    .out_valid(out_valid), .out_chan(out_chan)
);

// File: tb/fdm_resampler_bench.sv
module fdm_resampler_bench;

    localparam int NCH    = 24;
    localparam int ROUNDS = 300;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [4:0]         in_chan = '0;
    logic signed [15:0] in_sample = '0;
    logic [15:0]        in_freq = '0;
    logic               out_valid;
    logic [4:0]         out_chan;
    logic signed [15:0] out_i, out_q;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    int gph [NCH];
    int gn  [NCH];
    int gcnt[NCH];
    int glast_i[NCH];
    int glast_q[NCH];
    int hi [NCH][8];
    int hq [NCH][8];

    always #5 clk = ~clk;

    fdm_resampler u_fdm_resampler (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .in_freq(in_freq), .out_valid(out_valid),
        .out_chan(out_chan), .out_i(out_i), .out_q(out_q)
    );

    function automatic int qamp(input int q);
        case (q)
            0: return 32767;
            1: return 30274;
            2: return 23170;
            3: return 12540;
            default: return 0;
        endcase
    endfunction

    function automatic int ncos(input int k);
        if (k <= 4)       return qamp(k);
        else if (k <= 8)  return -qamp(8 - k);
        else if (k <= 12) return -qamp(k - 8);
        else              return qamp(16 - k);
    endfunction

    function automatic int hcoef(input int k);
        return (k < 48) ? 170 * (k + 1) : 170 * (96 - k);
    endfunction

    function automatic int rsat(input longint a);
        longint b;
        b = (a + 64'sd16384) >>> 15;
        if (b > 32767)  return 32767;
        if (b < -32768) return -32768;
        return int'(b);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input int ch, input int x, input int f);
        int k, mi, mq, r, ei, eq;
        longint ai, aq;
        bit emit;
        k  = gph[ch] >> 12;
        mi = int'((longint'(x) * ncos(k)) >>> 15);
        mq = int'((longint'(x) * ncos((k + 4) % 16)) >>> 15);
        for (int j = 7; j > 0; j--) begin
            hi[ch][j] = hi[ch][j-1];
            hq[ch][j] = hq[ch][j-1];
        end
        hi[ch][0] = mi;
        hq[ch][0] = mq;
        gph[ch] = (gph[ch] + f) % 65536;
        r = (25 - (12 * gn[ch]) % 25) % 25;
        gn[ch]++;
        emit = (r < 12);
        ei = 0;
        eq = 0;
        if (emit) begin
            ai = 0;
            aq = 0;
            for (int j = 0; j < 8; j++) begin
                ai += longint'(hcoef(r + 12 * j)) * hi[ch][j];
                aq += longint'(hcoef(r + 12 * j)) * hq[ch][j];
            end
            ei = rsat(ai);
            eq = rsat(aq);
        end

        @(negedge clk);
        in_valid  = 1'b1;
        in_chan   = 5'(ch);
        in_sample = 16'(x);
        in_freq   = 16'(f);
        @(negedge clk);
        in_valid  = 1'b0;
        repeat (9) @(negedge clk);
        check(out_valid == 1'b0, "R7", "early out_valid", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == emit, "R4", "out_valid", int'(out_valid), int'(emit));
        if (out_valid) begin
            gcnt[ch]++;
            glast_i[ch] = int'(out_i);
            glast_q[ch] = int'(out_q);
        end
        if (emit) begin
            check(int'(out_chan) == ch, "R8", "out_chan", int'(out_chan), ch);
            check(int'(out_i) == ei, "R2 R3 R5 R6", "out_i", int'(out_i), ei);
            check(int'(out_q) == eq, "R2 R3 R5 R6", "out_q", int'(out_q), eq);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int x, f;
        for (int c = 0; c < NCH; c++) begin
            gph[c] = 0; gn[c] = 0; gcnt[c] = 0; glast_i[c] = 0; glast_q[c] = 0;
            for (int j = 0; j < 8; j++) begin
                hi[c][j] = 0;
                hq[c][j] = 0;
            end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_i == 16'sd0, "R1", "out_i after reset", int'(out_i), 0);

        for (int rnd = 0; rnd < ROUNDS; rnd++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (ch == 0) begin
                    x = 32767; f = 0;
                end else if (ch == 1) begin
                    x = -32768; f = 0;
                end else if (ch == 2) begin
                    x = (rnd % 2 == 1) ? 20000 : -20000;
                    f = (rnd * 523) % 65536;
                end else begin
                    x = ((rnd * 7919 + ch * 1237 + rnd * rnd * 3) % 65536) - 32768;
                    f = (ch * 2731) % 65536;
                end
                send(ch, x, f);
            end
        end

        // R4: 144 outputs per 300 inputs on each channel
        for (int c = 0; c < NCH; c++)
            check(gcnt[c] == 144, "R4", "output count", gcnt[c], 144);
        // R6: saturation on full-scale DC channels
        check(glast_i[0] == 32767, "R6", "positive saturation", glast_i[0], 32767);
        check(glast_i[1] == -32768, "R6", "negative saturation", glast_i[1], -32768);
        check(glast_q[0] == 0, "R3", "zero quadrature at zero phase", glast_q[0], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule